// File: doc/BRIEF.md
# Three-Phase Scaled Sine Reference Generator

This block produces three signed 8-bit sinusoidal reference samples, each a third of a period apart, to feed the comparators of a sinusoidal PWM stage. A single 256-entry sine table serves all three channels. Each channel reads it through its own phase pointer, and a programmable clock-enable divider advances all three pointers together.

An 8-bit frequency code picks a precomputed divider period. The code selects an output frequency from 0.5 Hz to 60 Hz in 0.5 Hz steps. Each table sample is then multiplied by an 8-bit amplitude code and shifted right arithmetically by 7, which gives a gain between 0 and 127/128. All three scaled samples update on the same clock edge, and a one-cycle strobe marks that edge.

Top module: `sine3_ref_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the three sample outputs are 0 and `sample_stb` is 0.
- R2: Table entry k holds floor(127*sin(2*pi*k/256) + 0.5), for k = 0 to 255.
- R3: At strobe number n (counting from 0 after reset), channel A shows entry n mod 256, channel B shows entry (n+85) mod 256 and channel C shows entry (n+171) mod 256. All three are scaled, and all three change on the edge where the strobe is high.
- R4: The pointers advance by exactly one entry per strobe and wrap from 255 back to 0.
- R5: In steady state, consecutive strobes are D = max(1, floor(CLK_HZ / (128*(code+1)))) clock cycles apart. This gives an output frequency of (code+1)/2 Hz.
- R6: Frequency codes above 119 behave exactly like code 119 (60 Hz).
- R7: Each output equals (s*g) >>> 7, where s is the signed table sample and g is the amplitude code. The shift is an arithmetic shift that rounds toward minus infinity. The amplitude code used is the one present at the clock edge that raises the strobe.
- R8: Amplitude codes above 127 saturate to a gain of 127, so the result always fits in a signed 8-bit value.
- R9: The sample outputs do not change on any edge that does not assert the strobe.
- R10: The first strobe after reset carries table positions 0, 85 and 171.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_code | input | 8 | Output frequency select, (code+1)*0.5 Hz, saturating at 119 |
| amp_code | input | 8 | Amplitude gain numerator over 128, saturating at 127 |
| sample_a | output | 8 | Phase A scaled sample, signed |
| sample_b | output | 8 | Phase B scaled sample, signed, 85 entries ahead of A |
| sample_c | output | 8 | Phase C scaled sample, signed, 171 entries ahead of A |
| sample_stb | output | 1 | One-cycle pulse when the three samples update |

## Verification
Full gain is held at the fastest divider while the pointers sweep more than 256 positions. Every table entry is therefore seen on every channel, and the wrap is covered; this isolates table contents and phase offsets from the scaling. With the pointers still moving, all 256 amplitude codes are swept once each. This separates the truncating arithmetic shift on negative samples and the saturation above 127 from table errors. Strobe spacing is then measured for low, mid, boundary and out-of-range frequency codes. This distinguishes the divider formula, its floor at one cycle and the saturation of the code at 119.

// File: rtl/sine3_pkg.sv
`timescale 1ns/1ps
package sine3_pkg;

  localparam real TWO_PI = 6.28318530717958647692;

  // Rounded sine sample for table position k out of depth, peak magnitude peak.
  function automatic int sine_code(input int k, input int depth, input int peak);
    real x;
    x = $itor(peak) * $sin(TWO_PI * $itor(k) / $itor(depth));
    return int'($floor(x + 0.5));
  endfunction

  // Clock cycles per pointer step for frequency index idx: f = (idx+1)/2 Hz,
  // steps per second = depth*f, so cycles = 2*hz / (depth*(idx+1)), at least 1.
  function automatic int div_for(input longint hz, input int depth, input int idx);
    longint d;
    d = (2 * hz) / (longint'(depth) * longint'(idx + 1));
    if (d < 1) d = 1;
    return int'(d);
  endfunction

  // Rounded position offset of phase i among n phases over depth entries.
  function automatic int phase_offset(input int i, input int n, input int depth);
    return (2 * i * depth + n) / (2 * n);
  endfunction

endpackage

// File: rtl/step_divider.sv
`timescale 1ns/1ps
module step_divider #(
  parameter longint CLK_HZ = 27_000_000,
  parameter int     DEPTH  = 256,
  parameter int     CODE_W = 8,
  parameter int     STEPS  = 120,
  parameter int     CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] freq_code,
  output logic              tick
);
  localparam int IDX_W = $clog2(STEPS);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(STEPS - 1);

  logic [CNT_W-1:0] div_tab [STEPS];
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;

  // Precomputed period table, one entry per 0.5 Hz step
  for (genvar i = 0; i < STEPS; i++) begin : g_div
    localparam logic [CNT_W-1:0] PERIOD = CNT_W'(sine3_pkg::div_for(CLK_HZ, DEPTH, i));
    assign div_tab[i] = PERIOD;
  end

  // Codes beyond the table clamp to the top entry
  always_comb begin
    if (freq_code > TOP_CODE) idx = IDX_W'(STEPS - 1);
    else                      idx = IDX_W'(freq_code);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= div_tab[0];
    else     div_q <= div_tab[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_q - CNT_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/sine_table.sv
`timescale 1ns/1ps
module sine_table #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int PORTS  = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic        [ADDR_W-1:0] addr [PORTS],
  output logic signed [DATA_W-1:0] data [PORTS]
);
  localparam int PEAK = (1 << (DATA_W - 1)) - 1;

  logic signed [DATA_W-1:0] tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam logic signed [DATA_W-1:0] VAL = DATA_W'(sine3_pkg::sine_code(k, DEPTH, PEAK));
    assign tab[k] = VAL;
  end

  // Registered read ports on the shared table
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (en) data[p] <= tab[addr[p]];
    end
  end

endmodule

// File: rtl/gain_scaler.sv
`timescale 1ns/1ps
module gain_scaler #(
  parameter int DATA_W = 8,
  parameter int AMP_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] din,
  input  logic        [AMP_W-1:0]  amp,
  output logic signed [DATA_W-1:0] dout
);
  localparam int SHIFT = DATA_W - 1;
  localparam int PW    = DATA_W + AMP_W + 1;
  localparam logic [AMP_W-1:0] GMAX = AMP_W'((1 << SHIFT) - 1);

  logic        [AMP_W-1:0] gain;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    shifted;

  always_comb begin
    gain    = (amp > GMAX) ? GMAX : amp;
    prod    = PW'(din) * PW'($signed({1'b0, gain}));
    shifted = prod >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= shifted[DATA_W-1:0];
  end

endmodule

// File: rtl/sine3_ref_gen.sv
`timescale 1ns/1ps
module sine3_ref_gen #(
  parameter longint CLK_HZ = 27_000_000,
  parameter int     DEPTH  = 256,
  parameter int     DATA_W = 8,
  parameter int     CODE_W = 8,
  parameter int     AMP_W  = 8,
  parameter int     STEPS  = 120,
  parameter int     CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic        [CODE_W-1:0] freq_code,
  input  logic        [AMP_W-1:0]  amp_code,
  output logic signed [DATA_W-1:0] sample_a,
  output logic signed [DATA_W-1:0] sample_b,
  output logic signed [DATA_W-1:0] sample_c,
  output logic                     sample_stb
);
  localparam int PH     = 3;
  localparam int ADDR_W = $clog2(DEPTH);

  logic                     tick;
  logic                     rd_v;
  logic        [ADDR_W-1:0] ptr  [PH];
  logic signed [DATA_W-1:0] raw  [PH];
  logic signed [DATA_W-1:0] outs [PH];

  step_divider #(
    .CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .CODE_W(CODE_W), .STEPS(STEPS), .CNT_W(CNT_W)
  ) u_div (
    .clk(clk), .rst(rst), .freq_code(freq_code), .tick(tick)
  );

  // Phase pointers, each starting a third of the table apart
  for (genvar i = 0; i < PH; i++) begin : g_ptr
    localparam logic [ADDR_W-1:0] START = ADDR_W'(sine3_pkg::phase_offset(i, PH, DEPTH));
    always_ff @(posedge clk) begin
      if (rst)       ptr[i] <= START;
      else if (tick) ptr[i] <= ptr[i] + ADDR_W'(1);
    end
  end

  sine_table #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PORTS(PH)
  ) u_tab (
    .clk(clk), .en(tick), .addr(ptr), .data(raw)
  );

  for (genvar i = 0; i < PH; i++) begin : g_scale
    gain_scaler #(
      .DATA_W(DATA_W), .AMP_W(AMP_W)
    ) u_scale (
      .clk(clk), .rst(rst), .en(rd_v), .din(raw[i]), .amp(amp_code), .dout(outs[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v       <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      rd_v       <= tick;
      sample_stb <= rd_v;
    end
  end

  assign sample_a = outs[0];
  assign sample_b = outs[1];
  assign sample_c = outs[2];

endmodule

// File: rtl/sine3_ref_checker.sv
`timescale 1ns/1ps
module sine3_ref_checker #(
  parameter int DATA_W = 8,
  parameter int AMP_W  = 8,
  parameter int ADDR_W = 8,
  parameter int OFF_B  = 85,
  parameter int OFF_C  = 171
) (
  input logic                     clk,
  input logic                     rst,
  input logic        [AMP_W-1:0]  amp_code,
  input logic signed [DATA_W-1:0] sample_a,
  input logic signed [DATA_W-1:0] sample_b,
  input logic signed [DATA_W-1:0] sample_c,
  input logic                     sample_stb,
  input logic        [ADDR_W-1:0] ptr0,
  input logic        [ADDR_W-1:0] ptr1,
  input logic        [ADDR_W-1:0] ptr2
);
  int sum3;
  always_comb sum3 = int'(sample_a) + int'(sample_b) + int'(sample_c);

  // R9: outputs move only with the strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> ($stable(sample_a) && $stable(sample_b) && $stable(sample_c)));

  // R7: zero gain gives zero on every channel
  assert_zero_gain_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && $past(amp_code) == '0) |-> (sample_a == 0 && sample_b == 0 && sample_c == 0));

  // R3: three channels a third of a period apart nearly cancel
  assert_balanced_R3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (sum3 <= 8 && sum3 >= -8));

  // R3: pointer spacing is preserved
  assert_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    ((ptr1 - ptr0) == ADDR_W'(OFF_B)) && ((ptr2 - ptr0) == ADDR_W'(OFF_C)));

  // R4: pointer moves only by a single step
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ptr0 != $past(ptr0)) |-> (ptr0 == $past(ptr0) + ADDR_W'(1)));

endmodule

bind sine3_ref_gen sine3_ref_checker #(
  .DATA_W(DATA_W), .AMP_W(AMP_W), .ADDR_W(ADDR_W),
  .OFF_B(sine3_pkg::phase_offset(1, 3, DEPTH)),
  .OFF_C(sine3_pkg::phase_offset(2, 3, DEPTH))
) u_sine3_chk (
  .clk(clk), .rst(rst), .amp_code(amp_code),
  .sample_a(sample_a), .sample_b(sample_b), .sample_c(sample_c),
  .sample_stb(sample_stb), .ptr0(ptr[0]), .ptr1(ptr[1]), .ptr2(ptr[2])
);

// File: tb/test_sine3_ref_gen.sv
`timescale 1ns/1ps
module test_sine3_ref_gen;
  localparam longint CLK_HZ = 30720;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic        [7:0] freq_code = 8'd119;
  logic        [7:0] amp_code = 8'd127;
  logic signed [7:0] sample_a, sample_b, sample_c;
  logic              sample_stb;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int nstb = 0;
  int last_cyc = 0;
  int last_gap = 0;
  logic [7:0] amp_at_edge = 8'd0;
  logic signed [7:0] pa, pb, pc;
  bit done = 0;

  sine3_ref_gen #(.CLK_HZ(CLK_HZ)) i_sine3_ref_gen (
    .clk(clk), .rst(rst), .freq_code(freq_code), .amp_code(amp_code),
    .sample_a(sample_a), .sample_b(sample_b), .sample_c(sample_c),
    .sample_stb(sample_stb)
  );

  always #4 clk = ~clk;

  function automatic int tab(input int k);
    real x;
    x = 127.0 * $sin(6.28318530717958647692 * $itor(k % 256) / 256.0);
    return int'($floor(x + 0.5));
  endfunction

  function automatic int scaled(input int k, input int amp);
    int g;
    int p;
    g = (amp > 127) ? 127 : amp;
    p = tab(k) * g;
    return p >>> 7;
  endfunction

  function automatic int exp_div(input int code);
    int c;
    longint d;
    c = (code > 119) ? 119 : code;
    d = (2 * CLK_HZ) / (256 * (c + 1));
    return (d < 1) ? 1 : int'(d);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    amp_at_edge <= amp_code;
  end

  // Monitor: every strobe checked against table, offsets and gain (R2 R3 R4 R7 R8 R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (sample_stb) begin
        int ea, eb, ec;
        string tag;
        ea = scaled(nstb, amp_at_edge);
        eb = scaled(nstb + 85, amp_at_edge);
        ec = scaled(nstb + 171, amp_at_edge);
        if (nstb == 0) tag = "R10";
        else if (amp_at_edge > 127) tag = "R8";
        else if (nstb >= 256) tag = "R4";
        else tag = "R2/R3/R7";
        vectors++;
        if (int'(sample_a) != ea || int'(sample_b) != eb || int'(sample_c) != ec) begin
          fails++;
          $display("FAIL %s strobe %0d amp %0d: got %0d %0d %0d expected %0d %0d %0d",
                   tag, nstb, amp_at_edge, sample_a, sample_b, sample_c, ea, eb, ec);
        end
        last_gap = cyc - last_cyc;
        last_cyc = cyc;
        nstb++;
      end else if (cyc > 2 && (sample_a !== pa || sample_b !== pb || sample_c !== pc)) begin
        // R9: no change without a strobe
        fails++;
        $display("FAIL R9 cycle %0d: got %0d %0d %0d expected held %0d %0d %0d",
                 cyc, sample_a, sample_b, sample_c, pa, pb, pc);
      end
    end
    pa = sample_a;
    pb = sample_b;
    pc = sample_c;
  end

  task automatic wait_strobes(input int k);
    int target;
    target = nstb + k;
    while (nstb < target) @(posedge clk);
  endtask

  task automatic check_period(input int code, input string tag);
    @(negedge clk);
    freq_code = code[7:0];
    wait_strobes(3);
    vectors++;
    if (last_gap != exp_div(code)) begin
      fails++;
      $display("FAIL %s code %0d: gap %0d expected %0d", tag, code, last_gap, exp_div(code));
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    vectors++;
    if (sample_a != 0 || sample_b != 0 || sample_c != 0 || sample_stb != 0) begin
      fails++;
      $display("FAIL R1 in reset: got %0d %0d %0d stb %0b expected 0 0 0 stb 0",
               sample_a, sample_b, sample_c, sample_stb);
    end
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (sample_a != 0 || sample_b != 0 || sample_c != 0 || sample_stb != 0) begin
      fails++;
      $display("FAIL R1 after release: got %0d %0d %0d stb %0b expected 0 0 0 stb 0",
               sample_a, sample_b, sample_c, sample_stb);
    end

    // Full gain, fastest divider, past one full wrap (R2 R3 R4)
    wait_strobes(260);

    // Amplitude sweep over every code, out-of-range frequency code (R7 R8 R6)
    @(negedge clk);
    freq_code = 8'd200;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      amp_code = a[7:0];
      wait_strobes(1);
    end
    amp_code = 8'd100;

    // Strobe spacing (R5 R6)
    check_period(0, "R5");
    check_period(1, "R5");
    check_period(2, "R5");
    check_period(3, "R5");
    check_period(9, "R5");
    check_period(59, "R5");
    check_period(118, "R5");
    check_period(119, "R6");
    check_period(255, "R6");
    check_period(120, "R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule